// File: doc/BRIEF.md
# Mains zero-crossing pulse generator

This block turns the polarity of up to three mains phases into a single timing pulse for a controller that needs to follow the line frequency. Each phase arrives as one asynchronous bit from an external comparator on a divided phase voltage. That bit is high while the phase voltage is positive. The block watches every phase on its own and decides whether the phase looks like a real mains waveform. It then picks one trustworthy phase as the timing source. On each negative-to-positive crossing of that phase it drives a pulse of fixed width.

A phase that is missing or erratic never produces a pulse. When no phase qualifies, for example while the supply is up but every phase is disconnected, the output becomes a free-running train at 54 Hz. The controller therefore always sees a periodic signal, and it can tell the two regimes apart by their rate.

All timing constants are derived from the clock-frequency parameter. One millisecond is `CLK_HZ/1000` cycles, and the pulse width is its own parameter with a default of 1.5 ms.

Top module: `zc_pulse_gen`

## Requirements
- R1: While `rst_i` is high, `pulse_o` is low and every phase is treated as invalid. On the first clock edge after reset is released, the fallback train starts, because no phase is valid yet.
- R2: Each polarity bit passes through two synchronizer flops. A pulse caused by a phase crossing goes high three clock edges after the polarity bit rises: two synchronizer stages, then the output register.
- R3: Every pulse, whether it comes from a phase or from the fallback train, stays high for exactly `PULSE_CYC` cycles. The default is 1.5 ms, that is `(CLK_HZ/2000)*3`.
- R4: After a rising crossing is accepted, any further edge on that phase within 2 ms (`2*CLK_HZ/1000` cycles) is ignored. Chatter just after a crossing therefore neither changes the measured spacing nor creates a pulse.
- R5: A phase becomes valid when the spacing between two consecutive accepted rising crossings lies between 14 ms and 28 ms inclusive. An accepted crossing whose spacing falls outside that window clears the phase's validity.
- R6: A phase becomes invalid, and must again see two qualifying crossings, once 40 ms pass without an accepted rising crossing.
- R7: A phase pulse starts only at an accepted crossing of a phase that was already valid, and only if that crossing's spacing is inside the window. The crossing that first makes a phase valid produces no pulse, so a new phase produces its first pulse at its third crossing.
- R8: The timing source is chosen with fixed priority: phase 0 first, then 1, then 2. The block keeps the current source as long as that phase stays valid, even if a higher-priority phase becomes valid again. When the source turns invalid, the highest-priority valid phase takes over at its next qualifying crossing.
- R9: While no phase is valid, a pulse starts every `FB_CYC = round(CLK_HZ/54)` cycles. The first of these starts on the first cycle in which no phase is valid. The train stops as soon as any phase becomes valid, and a pulse already running is completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pol_i | input | NPH | Asynchronous polarity bit per phase; bit 0 is the highest-priority phase, and 1 means the phase voltage is positive |
| pulse_o | output | 1 | Zero-crossing timing pulse |

## Verification
The bound checker watches four properties on every clock edge:
- The output is low after any reset cycle.
- Every pulse has the programmed width.
- A phase becomes valid only in the cycle after one of its accepted crossings.
- While any phase is valid, a pulse starts only after an accepted crossing of a valid phase.

Other behaviours depend on long stretches of timing that only the bench scenarios can show. These are the spacing window and its edges, the 40 ms timeout, the exact cycle when the fallback train starts, the 54 Hz period, the chatter rejection, and the priority hand-over between phases. The bench sweeps the phase period across the window boundaries. For each scenario it computes the expected pulse spacing and the expected phase alignment arithmetically.

// File: rtl/zc_pulse_gen.sv
module zc_pulse_gen #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PULSE_CYC = (CLK_HZ / 2000) * 3,
  parameter int NPH       = 3
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [NPH-1:0] pol_i,
  output logic           pulse_o
);

  localparam int MS       = CLK_HZ / 1000;
  localparam int HOLD_CYC = 2 * MS;
  localparam int MIN_CYC  = 14 * MS;
  localparam int MAX_CYC  = 28 * MS;
  localparam int TMO_CYC  = 40 * MS;
  localparam int FB_CYC   = (CLK_HZ + 27) / 54;
  localparam int AW       = $clog2(TMO_CYC + 1);
  localparam int HW       = $clog2(HOLD_CYC + 1);
  localparam int PW       = $clog2(PULSE_CYC + 1);
  localparam int FW       = $clog2(FB_CYC);
  localparam int SW       = (NPH > 1) ? $clog2(NPH) : 1;

  logic [NPH-1:0] valid, acc, good;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic          s1, s2, s3, seen, v;
    logic [HW-1:0] hold;
    logic [AW-1:0] age;
    logic          in_win;

    assign in_win  = (age >= AW'(MIN_CYC)) && (age <= AW'(MAX_CYC));
    assign acc[g]  = s2 & ~s3 & (hold == '0);
    assign good[g] = acc[g] & seen & in_win;
    assign valid[g] = v;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        s3   <= 1'b0;
        hold <= '0;
        age  <= '0;
        seen <= 1'b0;
        v    <= 1'b0;
      end else begin
        s1 <= pol_i[g];
        s2 <= s1;
        s3 <= s2;
        if (acc[g])
          hold <= HW'(HOLD_CYC);
        else if (hold != '0)
          hold <= hold - 1'b1;
        if (acc[g]) begin
          age  <= AW'(1);
          seen <= 1'b1;
          v    <= good[g];
        end else if (age == AW'(TMO_CYC)) begin
          seen <= 1'b0;
          v    <= 1'b0;
        end else if (seen) begin
          age <= age + 1'b1;
        end
      end
    end
  end

  logic [SW-1:0] src, cand, eff;
  logic [PW-1:0] pcnt;
  logic [FW-1:0] fb_cnt;
  logic          any_v, start_ph, start_fb;

  always_comb begin
    cand = src;
    for (int i = NPH - 1; i >= 0; i--)
      if (valid[i]) cand = SW'(i);
  end

  assign eff      = valid[src] ? src : cand;
  assign any_v    = |valid;
  assign start_ph = valid[eff] & good[eff];
  assign start_fb = ~any_v & (fb_cnt == '0);
  assign pulse_o  = (pcnt != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      src    <= '0;
      pcnt   <= '0;
      fb_cnt <= '0;
    end else begin
      if (start_ph) src <= eff;
      if (any_v)
        fb_cnt <= '0;
      else
        fb_cnt <= (fb_cnt == FW'(FB_CYC - 1)) ? '0 : fb_cnt + 1'b1;
      if (start_ph || start_fb)
        pcnt <= PW'(PULSE_CYC);
      else if (pcnt != '0)
        pcnt <= pcnt - 1'b1;
    end
  end

endmodule

// File: rtl/zc_pulse_chk.sv
module zc_pulse_chk #(
  parameter int NPH       = 3,
  parameter int PULSE_CYC = 15
) (
  input logic           clk,
  input logic           rst,
  input logic           pulse_o,
  input logic [NPH-1:0] valid,
  input logic [NPH-1:0] acc
);

  localparam int CW = $clog2(PULSE_CYC + 2);

  logic [CW-1:0] hi;

  always_ff @(posedge clk) begin
    if (rst)
      hi <= '0;
    else if (pulse_o)
      hi <= (hi == CW'(PULSE_CYC + 1)) ? hi : hi + 1'b1;
    else
      hi <= '0;
  end

  // R1
  rst_low_chk: assert property (@(posedge clk) rst |=> !pulse_o);

  // R3
  width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> hi == CW'(PULSE_CYC));

  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(valid & ~$past(valid) & ~$past(acc))));

  // R7
  src_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pulse_o) && $past(|valid)) |-> $past(|(acc & valid)));

endmodule

bind zc_pulse_gen zc_pulse_chk #(.NPH(NPH), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk_i), .rst(rst_i), .pulse_o(pulse_o), .valid(valid), .acc(acc)
);

// File: tb/tb_zc_pulse_gen.sv
`timescale 1ns/1ps
module tb_zc_pulse_gen;
  localparam int CLK_HZ = 10000;
  localparam int PW     = 15;
  localparam int FB     = 185;
  localparam int MINP   = 140;
  localparam int MAXP   = 280;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] pol = '0;
  logic       pulse_o;

  zc_pulse_gen #(.CLK_HZ(CLK_HZ)) dut (
    .clk_i(clk), .rst_i(rst), .pol_i(pol), .pulse_o(pulse_o)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int per[3] = '{0, 0, 0};
  int t0[3]  = '{0, 0, 0};
  bit chat = 1'b0;
  bit inp = 1'b0;
  bit done = 1'b0;
  int last_rise = 0, prev_rise = 0, nrise = 0;
  int mark = 1 << 30, first_after = -1;

  task automatic chk_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit wave(input int i);
    int ph;
    bit v;
    if (per[i] == 0 || cyc < t0[i]) return 1'b0;
    ph = (cyc - t0[i]) % per[i];
    v  = ph < per[i] / 2;
    if (chat && ph >= 4 && ph < 6) v = 1'b0;
    return v;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      inp = 1'b0;
    end else if (pulse_o && !inp) begin
      inp = 1'b1;
      prev_rise = last_rise;
      last_rise = cyc;
      nrise++;
      if (first_after < 0 && cyc >= mark) first_after = cyc;
    end else if (!pulse_o && inp) begin
      inp = 1'b0;
      chk_eq("R3 pulse width", cyc - last_rise, PW);
    end
    for (int i = 0; i < 3; i++) pol[i] = wave(i);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    int rel;
    step(1);
    rst = 1'b1;
    chat = 1'b0;
    for (int i = 0; i < 3; i++) per[i] = 0;
    step(4);
    chk_eq("R1 low in reset", int'(pulse_o), 0);
    nrise = 0; last_rise = 0; prev_rise = 0;
    mark = 1 << 30; first_after = -1;
    rst = 1'b0;
    rel = cyc;
    step(3);
    chk_eq("R1/R9 first fallback pulse", last_rise, rel + 2);
  endtask

  task automatic align(input string tag, input int ph);
    chk_eq(tag, (last_rise - 3 - t0[ph]) % per[ph], 0);
  endtask

  initial begin
    int lst;
    int plist[19];

    // R1, R9: reset state and fallback train
    do_reset();
    step(800);
    chk_eq("R9 fallback period", last_rise - prev_rise, FB);

    // R2, R5, R7: one phase at 20 ms
    do_reset();
    t0[0] = cyc + 10; per[0] = 200;
    mark = t0[0] + 200 + 4;
    step(1400);
    chk_eq("R7 first phase pulse at third crossing", first_after, t0[0] + 400 + 3);
    align("R2 pulse aligned to crossing", 0);
    chk_eq("R5 period follows phase", last_rise - prev_rise, 200);

    // R6, R9: phase lost, timeout then fallback
    lst = t0[0] + ((cyc - t0[0]) / 200) * 200;
    per[0] = 0;
    mark = cyc; first_after = -1;
    step(1200);
    chk_eq("R6 timeout then fallback start", first_after, lst + 404);
    chk_eq("R9 fallback period after loss", last_rise - prev_rise, FB);

    // R5: sweep of the period across the window
    for (int k = 0; k < 17; k++) plist[k] = 130 + 10 * k;
    plist[17] = 139;
    plist[18] = 281;
    for (int k = 0; k < 19; k++) begin
      int p;
      bit inw;
      p = plist[k];
      inw = (p >= MINP) && (p <= MAXP);
      do_reset();
      t0[0] = cyc + 10; per[0] = p;
      step(5 * p + 400);
      chk_eq($sformatf("R5 period %0d", p), last_rise - prev_rise, inw ? p : FB);
      if (inw) align($sformatf("R2 align period %0d", p), 0);
    end

    // R8: priority and hand-over
    do_reset();
    t0[0] = cyc + 10; t0[1] = cyc + 60; t0[2] = cyc + 130;
    per[0] = 200; per[1] = 200; per[2] = 200;
    step(1500);
    align("R8 phase 0 chosen first", 0);
    per[0] = 0;
    step(1200);
    align("R8 switch to phase 1", 1);
    chk_eq("R8 period after switch", last_rise - prev_rise, 200);
    t0[0] = cyc + 10; per[0] = 200;
    step(1200);
    align("R8 source held while valid", 1);
    per[1] = 0;
    step(1200);
    align("R8 priority picks phase 0 over 2", 0);

    // R4: chatter right after each rising crossing
    do_reset();
    chat = 1'b1;
    t0[0] = cyc + 10; per[0] = 200;
    step(1400);
    chk_eq("R4 chatter ignored, period", last_rise - prev_rise, 200);
    align("R4 chatter ignored, alignment", 0);
    chat = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule